// File: doc/BRIEF.md
# Priority Pin Function Multiplexer

This block decides which of several candidate signals drives each multi-function pin of a chip. Software writes five 32-bit control words through a simple write port. A strap word is captured from an input at reset and cannot be written afterwards. For each pin, the block evaluates a fixed table of boolean expressions over scattered control and strap bits. Each expression is an AND of bit comparisons, and a comparison may require a 0 as well as a 1. The expressions feeding one priority level are ORed together.

Each pin has up to five levels, numbered 0 (strongest) to 4, plus a fallback. A level drives the pin only when it is active and every stronger level on that pin is inactive. When no level is active, the fallback drives the pin. The winning choice is registered and presented as a 3-bit code per pin. A read port returns any control word or the strap word, so that pin choices can be related to register contents.

The seven pins cover the interesting cases:
- a reset/chip-select pair decided by one bit's polarity;
- video-versus-UART pins that share an enable bit;
- an OR with a strap bit that must be 0;
- a pin whose GPIO signal sits at a strong level;
- a pin that uses all five levels.

Top module: `prio_pin_mux`

## Requirements
- R1: A synchronous active-high reset clears all five control words to zero and loads the strap word from `strap_in`. Until the first clock edge after reset, every pin code is 5 (fallback).
- R2: Register addresses are fixed as follows. Address 0..4 is a control word and a write there stores `wr_data`, which is visible on `rd_data` from the next cycle. Address 5 reads the strap word. Addresses 6 and 7 read 0, and writes to them change nothing.
- R3: A write to address 5 leaves the strap word, and every pin code, unchanged.
- R4: `pin_sel[3*i+2:3*i]` is the code of pin i: value k (0..4) names the winning level and 5 names the fallback. The code is registered, so a write at clock edge t changes pin codes at edge t+1, not at t.
- R5: A level wins only when it is active and every stronger level on the same pin is inactive; with no active level the code is 5.
- R6: Pin 0: level 0 = w0[3] & w1[15] & !w3[31]; level 1 = w0[3] & w1[15] & w3[31]; the two are never both active.
- R7: Pin 1: level 0 = (w3[5:4] != 0) & w2[17]; level 1 = w2[17].
- R8: Pins 2 and 3: level 0 = (w3[5:4] == 3) & w2[22] (pin 2) or w2[23] (pin 3); level 1 = the same enable bit alone.
- R9: Pin 4: level 0 = w1[25]; level 1 = w4[12] | !strap[19].
- R10: Pin 5: a GPIO signal at level 0 = w4[0]; level 1 = !strap[6]; its fallback is a non-GPIO signal.
- R11: Pin 6 uses five levels: level 0 = w1[0]; level 1 = w1[1]; level 2 = w2[0] & w3[0]; level 3 = w2[1] | strap[0]; level 4 = w4[4] & !w0[0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_in | input | 32 | Strap value captured during reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| pin_sel | output | 21 | Seven 3-bit pin codes, pin 0 in the low bits |

## Verification
A register write and the pin-code register update can fall in the same cycle. At the edge where a write lands, the resolvers still capture codes computed from the previous contents. The bench writes a word and samples both the read port and the pin codes after that edge. It expects the stored word to be visible already and every pin code to still match the old contents. One cycle later, it expects the codes derived from the new contents. Random writes across all eight addresses, done under two different strap values, push this overlap through every pin's priority chain.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    localparam int DATA_W     = 32;
    localparam int NUM_CTRL   = 5;
    localparam int ADDR_W     = 3;
    localparam int STRAP_IDX  = NUM_CTRL;
    localparam int NUM_PINS   = 7;
    localparam int NUM_LEVELS = 5;
    localparam int SEL_W      = $clog2(NUM_LEVELS + 1);
    localparam logic [SEL_W-1:0] SEL_FALLBACK = SEL_W'(NUM_LEVELS);

    // Control word roles
    localparam int W_RST  = 0;
    localparam int W_FUNC = 1;
    localparam int W_SER  = 2;
    localparam int W_VID  = 3;
    localparam int W_AUX  = 4;

    typedef logic [NUM_CTRL-1:0][DATA_W-1:0]   ctrl_bank_t;
    typedef logic [NUM_PINS-1:0][NUM_LEVELS-1:0] pin_levels_t;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] strap_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output ctrl_bank_t        ctrl_o,
    output logic [DATA_W-1:0] strap_o
);
    ctrl_bank_t        ctrl_q;
    logic [DATA_W-1:0] strap_q;

    // Strap word: loaded only while in reset
    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_in;
    end

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                ctrl_q[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
                ctrl_q[g] <= wr_data;
        end

        // R2: a write to a control address lands next cycle
        a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == ADDR_W'(g)) |=> (ctrl_q[g] == $past(wr_data)));
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(STRAP_IDX))
            rd_data = strap_q;
        for (int i = 0; i < NUM_CTRL; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = ctrl_q[i];
    end

    assign ctrl_o  = ctrl_q;
    assign strap_o = strap_q;

    // R3: strap writes have no effect
    a_r3_strap_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(STRAP_IDX)) |=> $stable(strap_q));

    // R2: unused addresses change nothing
    a_r2_unused_addr: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > ADDR_W'(STRAP_IDX)) |=> $stable(ctrl_q));
endmodule

// File: rtl/pinmux_expr.sv
module pinmux_expr
    import pinmux_pkg::*;
(
    input  ctrl_bank_t        ctrl,
    input  logic [DATA_W-1:0] strap,
    output pin_levels_t       act
);
    logic [1:0] vid_mode;
    logic       rst_pair;
    logic       unused_bits;

    assign vid_mode    = ctrl[W_VID][5:4];
    assign rst_pair    = ctrl[W_RST][3] & ctrl[W_FUNC][15];
    assign unused_bits = ^{ctrl, strap};

    always_comb begin
        act = '0;
        // Pin 0: reset vs chip-select by polarity of one bit
        act[0][0] = rst_pair & ~ctrl[W_VID][31];
        act[0][1] = rst_pair &  ctrl[W_VID][31];
        // Pin 1: video enable when any video mode, else UART
        act[1][0] = (vid_mode != 2'd0) & ctrl[W_SER][17];
        act[1][1] = ctrl[W_SER][17];
        // Pins 2, 3: video data only in the widest mode
        act[2][0] = (vid_mode == 2'd3) & ctrl[W_SER][22];
        act[2][1] = ctrl[W_SER][22];
        act[3][0] = (vid_mode == 2'd3) & ctrl[W_SER][23];
        act[3][1] = ctrl[W_SER][23];
        // Pin 4: OR with an active-low strap term
        act[4][0] = ctrl[W_FUNC][25];
        act[4][1] = ctrl[W_AUX][12] | ~strap[19];
        // Pin 5: GPIO at the strong level
        act[5][0] = ctrl[W_AUX][0];
        act[5][1] = ~strap[6];
        // Pin 6: five levels
        act[6][0] = ctrl[W_FUNC][0];
        act[6][1] = ctrl[W_FUNC][1];
        act[6][2] = ctrl[W_SER][0] & ctrl[W_VID][0];
        act[6][3] = ctrl[W_SER][1] | strap[0];
        act[6][4] = ctrl[W_AUX][4] & ~ctrl[W_RST][0];
    end
endmodule

// File: rtl/pinmux_resolve.sv
module pinmux_resolve
    import pinmux_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LEVELS-1:0] lv,
    output logic [SEL_W-1:0]      sel_q
);
    logic [SEL_W-1:0] sel_d;

    always_comb begin
        sel_d = SEL_FALLBACK;
        for (int k = NUM_LEVELS - 1; k >= 0; k--)
            if (lv[k]) sel_d = SEL_W'(k);
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= SEL_FALLBACK;
        else     sel_q <= sel_d;
    end

    // R5: strongest level always wins
    a_r5_top_level_wins: assert property (@(posedge clk) disable iff (rst)
        lv[0] |=> (sel_q == '0));

    // R5: no active level gives the fallback
    a_r5_fallback: assert property (@(posedge clk) disable iff (rst)
        (lv == '0) |=> (sel_q == SEL_FALLBACK));

    for (genvar k = 1; k < NUM_LEVELS; k++) begin : g_lvl
        // R5: weaker level wins only when all stronger are inactive
        a_r5_level_wins: assert property (@(posedge clk) disable iff (rst)
            (lv[k] && !(|lv[k-1:0])) |=> (sel_q == SEL_W'(k)));
    end

    // R4: code range
    a_r4_code_range: assert property (@(posedge clk) disable iff (rst)
        sel_q <= SEL_FALLBACK);
endmodule

// File: rtl/prio_pin_mux.sv
module prio_pin_mux
    import pinmux_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [DATA_W-1:0]          strap_in,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_PINS*SEL_W-1:0]  pin_sel
);
    ctrl_bank_t        ctrl;
    logic [DATA_W-1:0] strap;
    pin_levels_t       act;

    pinmux_regs u_regs (
        .clk(clk), .rst(rst), .strap_in(strap_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ctrl_o(ctrl), .strap_o(strap)
    );

    pinmux_expr u_expr (
        .ctrl(ctrl), .strap(strap), .act(act)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pinmux_resolve u_res (
            .clk(clk), .rst(rst), .lv(act[p]),
            .sel_q(pin_sel[p*SEL_W +: SEL_W])
        );
    end

    // R6: reset and chip-select never requested together
    a_r6_pair_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(act[0][0] && act[0][1]));

    // R8: video data level implies its enable level
    a_r8_video_implies_enable: assert property (@(posedge clk) disable iff (rst)
        (act[2][0] |-> act[2][1]));
endmodule

// File: tb/prio_pin_mux_tb.sv
module prio_pin_mux_tb;
    localparam int NP = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] strap_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [NP*3-1:0] pin_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_w [5];
    logic [31:0] m_strap;

    prio_pin_mux u_dut (
        .clk(clk), .rst(rst), .strap_in(strap_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_sel(pin_sel)
    );

    always #10 clk = ~clk;

    function automatic string pin_tag(int p);
        case (p)
            0: return "R6";
            1: return "R7";
            2, 3: return "R8";
            4: return "R9";
            5: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [4:0] levels(int p);
        logic [4:0] l = '0;
        logic [1:0] vm = m_w[3][5:4];
        case (p)
            0: begin
                l[0] = m_w[0][3] & m_w[1][15] & ~m_w[3][31];
                l[1] = m_w[0][3] & m_w[1][15] &  m_w[3][31];
            end
            1: begin l[0] = (vm != 0) & m_w[2][17]; l[1] = m_w[2][17]; end
            2: begin l[0] = (vm == 3) & m_w[2][22]; l[1] = m_w[2][22]; end
            3: begin l[0] = (vm == 3) & m_w[2][23]; l[1] = m_w[2][23]; end
            4: begin l[0] = m_w[1][25]; l[1] = m_w[4][12] | ~m_strap[19]; end
            5: begin l[0] = m_w[4][0]; l[1] = ~m_strap[6]; end
            default: begin
                l[0] = m_w[1][0];
                l[1] = m_w[1][1];
                l[2] = m_w[2][0] & m_w[3][0];
                l[3] = m_w[2][1] | m_strap[0];
                l[4] = m_w[4][4] & ~m_w[0][0];
            end
        endcase
        return l;
    endfunction

    function automatic logic [2:0] exp_sel(int p);
        logic [4:0] l = levels(p);
        for (int k = 0; k < 5; k++)
            if (l[k]) return 3'(k);
        return 3'd5;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_pins(string why);
        for (int p = 0; p < NP; p++)
            check($sformatf("%s pin%0d %s", pin_tag(p), p, why),
                  32'(pin_sel[p*3 +: 3]), 32'(exp_sel(p)));
    endtask

    task automatic do_reset(logic [31:0] s);
        @(negedge clk);
        rst = 1'b1; strap_in = s; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        for (int p = 0; p < NP; p++)
            check("R1 fallback in reset", 32'(pin_sel[p*3 +: 3]), 32'd5);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) m_w[i] = '0;
        m_strap = s;
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            check("R1 readback after reset", rd_data, (a == 5) ? s : 32'd0);
        end
        @(negedge clk);
        check_pins("R1 after reset");
    endtask

    // Write, then verify old codes at the write edge and new ones one edge later
    task automatic do_write(logic [2:0] a, logic [31:0] d);
        logic [2:0] old [NP];
        for (int p = 0; p < NP; p++) old[p] = exp_sel(p);
        wr_en = 1'b1; wr_addr = a; wr_data = d; rd_addr = a;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 5) m_w[a] = d;
        #1;
        check("R2 R3 read after write", rd_data,
              (a < 5) ? m_w[a] : ((a == 5) ? m_strap : 32'd0));
        for (int p = 0; p < NP; p++)
            check("R4 code not yet updated", 32'(pin_sel[p*3 +: 3]), 32'(old[p]));
        @(negedge clk);
        check_pins("R5 after write");
    endtask

    task automatic random_phase(int n);
        for (int i = 0; i < n; i++) begin
            logic [2:0]  a = 3'($urandom_range(0, 7));
            logic [31:0] d = $urandom();
            do_write(a, d);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        do_reset(32'h0008_0041);

        // R6 directed: reset vs chip-select by polarity of w3[31]
        do_write(3'd0, 32'h8); do_write(3'd1, 32'h8000);
        check("R6 reset signal", 32'(pin_sel[2:0]), 32'd0);
        do_write(3'd3, 32'h8000_0000);
        check("R6 chip select", 32'(pin_sel[2:0]), 32'd1);

        // R7 / R8: mode 1 enables pin 1 video but not pins 2/3
        do_write(3'd2, 32'h00C2_0000); do_write(3'd3, 32'h10);
        check("R7 video in mode 1", 32'(pin_sel[5:3]), 32'd0);
        check("R8 uart in mode 1", 32'(pin_sel[8:6]), 32'd1);
        do_write(3'd3, 32'h30);
        check("R8 video in mode 3", 32'(pin_sel[11:9]), 32'd0);

        // R3: strap write ignored, codes unchanged
        do_write(3'd5, 32'hFFFF_FFFF);
        check("R3 strap unchanged", rd_data, 32'h0008_0041);

        // R10: GPIO at level 0 overrides strap-enabled level 1
        do_write(3'd4, 32'h1);
        check("R10 gpio strong", 32'(pin_sel[17:15]), 32'd0);

        // R11: peel pin 6 levels one by one
        do_write(3'd1, 32'h3);
        check("R11 level0", 32'(pin_sel[20:18]), 32'd0);
        do_write(3'd1, 32'h2);
        check("R11 level1", 32'(pin_sel[20:18]), 32'd1);
        do_write(3'd2, 32'h1); do_write(3'd3, 32'h1); do_write(3'd1, 32'h0);
        check("R11 level2", 32'(pin_sel[20:18]), 32'd2);

        random_phase(300);

        // Second strap value: strap[19]=0, strap[6]=0, strap[0]=0
        do_reset(32'h0000_0000);
        check("R9 strap-low term", 32'(pin_sel[14:12]), 32'd1);
        check("R10 strap level", 32'(pin_sel[17:15]), 32'd1);
        check("R11 fallback", 32'(pin_sel[20:18]), 32'd5);
        do_write(3'd4, 32'h10);
        check("R11 level4", 32'(pin_sel[20:18]), 32'd4);
        do_write(3'd0, 32'h1);
        check("R11 level4 blocked", 32'(pin_sel[20:18]), 32'd5);
        do_write(3'd6, 32'hFFFF_FFFF);
        do_write(3'd7, 32'hFFFF_FFFF);
        random_phase(300);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule